// File: doc/BRIEF.md
# Serial Peripheral Master with Command-Then-Read Transfers

This block drives one serial peripheral device over a four-wire link (SCLK, MOSI, MISO and an active-low select). The host fills a transmit queue and drains a receive queue through simple push/pop strobes. It sets the link through three configuration fields: a transfer mode, a reply frame count and a clock half-period. A start strobe launches a transfer while the block is enabled.

Four transfer modes exist. Full duplex sends and captures every frame. Send-only sends frames and keeps nothing. Fetch-only drives a fixed level on MOSI and captures a programmed number of frames. The command-then-read mode first sends every frame waiting in the transmit queue and ignores MISO while doing so. Once that queue runs dry it switches by itself to capturing replies, without releasing the select line. This lets a memory device receive its opcode and address bytes and then stream data back in one unbroken transaction. The configuration fields are locked while the block is enabled, so any software-driven mode change would release the select line and abort the device's transaction. The automatic switch avoids that.

Top module: `spi_eeprom_master`

## Requirements
- R1: The mode field `cfg_mode` decodes as 0 = full duplex, 1 = send only, 2 = fetch only, 3 = command-then-read. A start while enabled in modes 0, 1 or 3 begins a transfer only if the transmit queue holds a frame. In mode 2 a start always begins one.
- R2: After reset, `ss_n` is 1, `sclk` is 0, `mosi` is 0, `busy` is 0, both queues are empty, the mode is 0, the reply count is 0 and the half-period is 1.
- R3: Frames are 8 bits, MSB first, with SCLK idle low. MOSI changes only while SCLK is low, and MISO is sampled as SCLK rises. Each SCLK phase lasts `cfg_half` system cycles, with 0 treated as 1. SCLK stays low whenever `ss_n` is high.
- R4: In mode 3, frames from the transmit queue go out on MOSI first. Nothing is written to the receive queue for these frames.
- R5: In mode 3, once a sent frame ends with the transmit queue empty, MOSI is held at the fixed level 0. Exactly `cfg_count`+1 frames are then captured into the receive queue in arrival order, and `ss_n` stays low from the first frame to the last.
- R6: In mode 3, every queued frame is sent, including frames beyond the opcode and address. The reply bits arriving during those extra frames are discarded.
- R7: `cfg_we` loads the mode, reply count and half-period only while `enable` is 0. A write while `enable` is 1 has no effect.
- R8: In mode 2, MOSI stays at 0 and exactly `cfg_count`+1 frames are captured.
- R9: In mode 0, each sent frame's reply is captured, and the transfer ends when a frame finishes with the transmit queue empty. In mode 1, nothing is captured.
- R10: If a frame that must be captured ends while the receive queue is full, SCLK is held high and `ss_n` held low until space frees. No frame is lost.
- R11: `busy` equals the inverse of `ss_n`. `ss_n` is high when idle or disabled. Dropping `enable` mid-transfer raises `ss_n` at the next clock, and the partial frame is dropped.
- R12: Each queue holds 8 frames and has full and empty flags. A push to a full transmit queue and a pop from an empty receive queue are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; low aborts and unlocks configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Transfer mode to load |
| cfg_count | input | 8 | Reply frame count minus one to load |
| cfg_half | input | 8 | SCLK half-period in system cycles to load |
| start | input | 1 | Transfer launch strobe |
| tx_push | input | 1 | Transmit queue push |
| tx_data | input | 8 | Frame to push |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_pop | input | 1 | Receive queue pop |
| rx_data | output | 8 | Oldest received frame |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| busy | output | 1 | Transfer in progress |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low device select |

## Verification
Two functions can land on the same clock: the end of a captured frame, which writes the receive queue, and a host pop that frees a slot in that queue. The bench provokes this by starting a long fetch with pops withheld until the queue fills and SCLK freezes high. It then pops at a steady rate so that releases fall on the very cycle a stalled frame completes. The reference model works from the pre-edge queue fill and the pop strobe. It predicts the stall release cycle, the SCLK waveform and the order of every frame leaving the queue, and these are compared on each clock.

// File: rtl/spim_pkg.sv
package spim_pkg;
   typedef enum logic [1:0] {
      MD_DUPLEX  = 2'd0,
      MD_SEND    = 2'd1,
      MD_FETCH   = 2'd2,
      MD_CMDREAD = 2'd3
   } xfer_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOW  = 2'd1,
      ST_HIGH = 2'd2
   } eng_state_e;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
   parameter int W = 8,
   parameter int D = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         full,
   output logic         empty
);
   localparam int AW = (D > 1) ? $clog2(D) : 1;
   localparam int CW = $clog2(D + 1);

   initial begin
      assert (D >= 2) else $error("queue depth must be at least 2");
   end

   logic [W-1:0]  mem [D];
   logic [AW-1:0] wp, rp;
   logic [CW-1:0] fill;
   logic          do_push, do_pop;

   assign full    = (fill == CW'(D));
   assign empty   = (fill == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp   <= '0;
         rp   <= '0;
         fill <= '0;
      end else begin
         if (do_push) wp <= (wp == AW'(D - 1)) ? '0 : wp + 1'b1;
         if (do_pop)  rp <= (rp == AW'(D - 1)) ? '0 : rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   fill <= fill + 1'b1;
            2'b01:   fill <= fill - 1'b1;
            default: fill <= fill;
         endcase
      end
   end
endmodule

// File: rtl/spim_engine.sv
module spim_engine
   import spim_pkg::*;
#(
   parameter int   FW       = 8,
   parameter int   NW       = 8,
   parameter int   DW       = 8,
   parameter logic HOLD_LVL = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          start,
   input  xfer_mode_e    mode,
   input  logic [NW-1:0] nfr,
   input  logic [DW-1:0] half,
   input  logic          tx_empty,
   input  logic [FW-1:0] tx_rdata,
   output logic          tx_pop,
   input  logic          rx_full,
   output logic          rx_push,
   output logic [FW-1:0] rx_wdata,
   input  logic          miso,
   output logic          sclk,
   output logic          mosi,
   output logic          ss_n
);
   localparam int BW = (FW > 1) ? $clog2(FW) : 1;

   eng_state_e    state;
   logic [DW-1:0] cnt, half_m1;
   logic [BW-1:0] bitn;
   logic [NW-1:0] rcnt;
   logic [FW-1:0] tsh, rsh;
   logic          txph;
   logic          rxing, at_edge, last_bit, frame_end, stall;
   logic          launch, cont, go_rd;

   assign half_m1   = (half == '0) ? '0 : half - 1'b1;
   assign at_edge   = (cnt == half_m1);
   assign last_bit  = (bitn == BW'(FW - 1));
   assign rxing     = (mode == MD_DUPLEX) || (mode == MD_FETCH) ||
                      ((mode == MD_CMDREAD) && !txph);
   assign frame_end = (state == ST_HIGH) && at_edge && last_bit;
   assign stall     = frame_end && rxing && rx_full;
   assign rx_wdata  = rsh;

   always_comb begin
      launch  = 1'b0;
      cont    = 1'b0;
      go_rd   = 1'b0;
      tx_pop  = 1'b0;
      rx_push = 1'b0;
      if (state == ST_IDLE) begin
         launch = en && start && ((mode == MD_FETCH) || !tx_empty);
         tx_pop = launch && (mode != MD_FETCH);
      end else if (frame_end && !stall && en) begin
         rx_push = rxing;
         case (mode)
            MD_DUPLEX, MD_SEND: begin
               cont   = !tx_empty;
               tx_pop = !tx_empty;
            end
            MD_FETCH: cont = (rcnt != nfr);
            default: begin
               if (txph) begin
                  cont   = 1'b1;
                  tx_pop = !tx_empty;
                  go_rd  = tx_empty;
               end else begin
                  cont = (rcnt != nfr);
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
         bitn  <= '0;
         rcnt  <= '0;
         tsh   <= '0;
         rsh   <= '0;
         txph  <= 1'b0;
      end else if (state != ST_IDLE && !en) begin
         state <= ST_IDLE;
      end else begin
         case (state)
            ST_IDLE: if (launch) begin
               state <= ST_LOW;
               cnt   <= '0;
               bitn  <= '0;
               rcnt  <= '0;
               txph  <= (mode != MD_FETCH);
               tsh   <= tx_pop ? tx_rdata : '0;
            end
            ST_LOW: if (at_edge) begin
               state <= ST_HIGH;
               cnt   <= '0;
               rsh   <= {rsh[FW-2:0], miso};
            end else begin
               cnt <= cnt + 1'b1;
            end
            default: if (!at_edge) begin
               cnt <= cnt + 1'b1;
            end else if (!last_bit) begin
               state <= ST_LOW;
               cnt   <= '0;
               bitn  <= bitn + 1'b1;
               tsh   <= {tsh[FW-2:0], 1'b0};
            end else if (!stall) begin
               if (rx_push) rcnt <= rcnt + 1'b1;
               if (tx_pop)  tsh  <= tx_rdata;
               if (go_rd)   txph <= 1'b0;
               cnt   <= '0;
               bitn  <= '0;
               state <= cont ? ST_LOW : ST_IDLE;
            end
         endcase
      end
   end

   assign sclk = (state == ST_HIGH);
   assign ss_n = (state == ST_IDLE);
   assign mosi = (state != ST_IDLE && txph) ? tsh[FW-1] : HOLD_LVL;
endmodule

// File: rtl/spi_eeprom_master.sv
module spi_eeprom_master
   import spim_pkg::*;
#(
   parameter int   FRAME_W  = 8,
   parameter int   DEPTH    = 8,
   parameter int   CNT_W    = 8,
   parameter int   DIV_W    = 8,
   parameter logic HOLD_LVL = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               cfg_we,
   input  logic [1:0]         cfg_mode,
   input  logic [CNT_W-1:0]   cfg_count,
   input  logic [DIV_W-1:0]   cfg_half,
   input  logic               start,
   input  logic               tx_push,
   input  logic [FRAME_W-1:0] tx_data,
   output logic               tx_full,
   output logic               tx_empty,
   input  logic               rx_pop,
   output logic [FRAME_W-1:0] rx_data,
   output logic               rx_full,
   output logic               rx_empty,
   output logic               busy,
   output logic               sclk,
   output logic               mosi,
   input  logic               miso,
   output logic               ss_n
);
   initial begin
      assert (FRAME_W >= 2) else $error("frame width too small");
      assert (CNT_W >= 1 && DIV_W >= 1) else $error("field widths must be positive");
   end

   xfer_mode_e         mode_q;
   logic [CNT_W-1:0]   count_q;
   logic [DIV_W-1:0]   half_q;
   logic               eng_tx_pop, eng_rx_push;
   logic [FRAME_W-1:0] tx_head, rx_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= MD_DUPLEX;
         count_q <= '0;
         half_q  <= DIV_W'(1);
      end else if (cfg_we && !enable) begin
         mode_q  <= xfer_mode_e'(cfg_mode);
         count_q <= cfg_count;
         half_q  <= cfg_half;
      end
   end

   spim_fifo #(.W(FRAME_W), .D(DEPTH)) u_txq (
      .clk, .rst_n,
      .push(tx_push), .wdata(tx_data),
      .pop(eng_tx_pop), .rdata(tx_head),
      .full(tx_full), .empty(tx_empty)
   );

   spim_fifo #(.W(FRAME_W), .D(DEPTH)) u_rxq (
      .clk, .rst_n,
      .push(eng_rx_push), .wdata(rx_word),
      .pop(rx_pop), .rdata(rx_data),
      .full(rx_full), .empty(rx_empty)
   );

   spim_engine #(.FW(FRAME_W), .NW(CNT_W), .DW(DIV_W), .HOLD_LVL(HOLD_LVL)) u_eng (
      .clk, .rst_n,
      .en(enable), .start,
      .mode(mode_q), .nfr(count_q), .half(half_q),
      .tx_empty, .tx_rdata(tx_head), .tx_pop(eng_tx_pop),
      .rx_full, .rx_push(eng_rx_push), .rx_wdata(rx_word),
      .miso, .sclk, .mosi, .ss_n
   );

   assign busy = ~ss_n;
endmodule

// File: rtl/spim_checker.sv
module spim_checker #(
   parameter logic HOLD_LVL = 1'b0
) (
   input logic       clk,
   input logic       rst_n,
   input logic       enable,
   input logic       sclk,
   input logic       mosi,
   input logic       ss_n,
   input logic       tx_full,
   input logic       tx_empty,
   input logic       rx_full,
   input logic       rx_empty,
   input logic [1:0] mode_q
);
   AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      ss_n |-> !sclk);                                              // R3
   AST_OFF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> ss_n);                                            // R11
   AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      enable |=> $stable(mode_q));                                  // R7
   AST_FETCH_MOSI: assert property (@(posedge clk) disable iff (!rst_n)
      (!ss_n && mode_q == 2'd2) |-> (mosi == HOLD_LVL));            // R8
   AST_TX_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_full && tx_empty));                                      // R12
   AST_RX_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_full && rx_empty));                                      // R12
endmodule

bind spi_eeprom_master spim_checker #(.HOLD_LVL(HOLD_LVL)) u_chk (
   .clk, .rst_n, .enable, .sclk, .mosi, .ss_n,
   .tx_full, .tx_empty, .rx_full, .rx_empty,
   .mode_q(mode_q)
);

// File: tb/tb_spi_eeprom_master.sv
module tb_spi_eeprom_master;
   localparam int CLK_P = 10;
   localparam int DEPTH = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic enable = 0, cfg_we = 0, start = 0, tx_push = 0, rx_pop = 0, miso = 0;
   logic [1:0] cfg_mode = 0;
   logic [7:0] cfg_count = 0, cfg_half = 0, tx_data = 0;
   logic tx_full, tx_empty, rx_full, rx_empty, busy, sclk, mosi, ss_n;
   logic [7:0] rx_data;

   int checks = 0, errors = 0;
   bit done = 0;

   always #(CLK_P/2) clk = ~clk;

   spi_eeprom_master dut (
      .clk, .rst_n, .enable, .cfg_we, .cfg_mode, .cfg_count, .cfg_half,
      .start, .tx_push, .tx_data, .tx_full, .tx_empty,
      .rx_pop, .rx_data, .rx_full, .rx_empty, .busy,
      .sclk, .mosi, .miso, .ss_n
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- slave device: byte for frame k is A0+k --------------
   int s_bp = 0, s_fk = 0;
   logic s_prev = 0;
   int rises = 0;
   always @(negedge clk) begin
      if (ss_n) begin s_bp = 0; s_fk = 0; end
      else if (s_prev && !sclk) begin
         s_bp++;
         if (s_bp == 8) begin s_bp = 0; s_fk++; end
      end
      if (sclk && !s_prev) rises++;
      s_prev = sclk;
      miso <= 8'(8'hA0 + s_fk) >> (7 - s_bp);
   end

   // ---------------- behavioural reference model -------------------------
   logic [7:0] txq[$], rxq[$];
   int m_state = 0, m_cnt = 0, m_bit = 0, m_rcnt = 0;
   int m_mode = 0, m_nfr = 0, m_div = 1;
   bit m_txph = 0;
   logic [7:0] m_sh = 0, m_rsh = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         txq.delete(); rxq.delete();
         m_state = 0; m_cnt = 0; m_bit = 0; m_rcnt = 0; m_txph = 0;
         m_mode = 0; m_nfr = 0; m_div = 1; m_sh = 0; m_rsh = 0;
      end else begin
         int h, tx_n, rx_n;
         bit pop_t, push_r, rxing, cont;
         logic [7:0] pr;
         h = (m_div == 0) ? 1 : m_div;
         tx_n = txq.size(); rx_n = rxq.size();
         pop_t = 0; push_r = 0; pr = 0; cont = 0;
         if (m_state != 0 && !enable) m_state = 0;
         else if (m_state == 0) begin
            if (enable && start && (m_mode == 2 || tx_n > 0)) begin
               m_state = 1; m_cnt = 0; m_bit = 0; m_rcnt = 0;
               m_txph = (m_mode != 2);
               if (m_mode != 2) begin m_sh = txq[0]; pop_t = 1; end
               else m_sh = 0;
            end
         end else if (m_state == 1) begin
            if (m_cnt == h - 1) begin m_state = 2; m_cnt = 0; m_rsh = {m_rsh[6:0], miso}; end
            else m_cnt++;
         end else begin
            if (m_cnt != h - 1) m_cnt++;
            else if (m_bit != 7) begin m_state = 1; m_cnt = 0; m_bit++; m_sh = m_sh << 1; end
            else begin
               rxing = (m_mode == 0) || (m_mode == 2) || (m_mode == 3 && !m_txph);
               if (!(rxing && rx_n == DEPTH)) begin
                  case (m_mode)
                     0, 1: if (tx_n > 0) begin cont = 1; pop_t = 1; m_sh = txq[0]; end
                     2: cont = (m_rcnt != m_nfr);
                     default:
                        if (m_txph) begin
                           cont = 1;
                           if (tx_n > 0) begin pop_t = 1; m_sh = txq[0]; end
                           else m_txph = 0;
                        end else cont = (m_rcnt != m_nfr);
                  endcase
                  if (rxing) begin push_r = 1; pr = m_rsh; m_rcnt++; end
                  m_state = cont ? 1 : 0; m_cnt = 0; m_bit = 0;
               end
            end
         end
         if (pop_t) void'(txq.pop_front());
         if (tx_push && tx_n < DEPTH) txq.push_back(tx_data);
         if (rx_pop && rx_n > 0) void'(rxq.pop_front());
         if (push_r) rxq.push_back(pr);
         if (cfg_we && !enable) begin m_mode = cfg_mode; m_nfr = cfg_count; m_div = cfg_half; end
      end
   end

   // every-clock comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic exp_mosi;
         exp_mosi = (m_state != 0 && m_txph) ? m_sh[7] : 1'b0;
         chk(ss_n == (m_state == 0), "R11 ss_n", ss_n, m_state == 0);
         chk(busy == (m_state != 0), "R11 busy", busy, m_state != 0);
         chk(sclk == (m_state == 2), "R3 sclk", sclk, m_state == 2);
         chk(mosi == exp_mosi, "R3 mosi", mosi, exp_mosi);
         chk(tx_empty == (txq.size() == 0) && tx_full == (txq.size() == DEPTH),
             "R12 tx flags", {tx_full, tx_empty}, txq.size());
         chk(rx_empty == (rxq.size() == 0) && rx_full == (rxq.size() == DEPTH),
             "R12 rx flags", {rx_full, rx_empty}, rxq.size());
         if (rxq.size() > 0) chk(rx_data == rxq[0], "R5 rx head", rx_data, rxq[0]);
      end
   end

   // ---------------- stimulus tasks --------------------------------------
   task automatic cfg(input int md, input int n, input int hv);
      @(negedge clk); cfg_we = 1; cfg_mode = 2'(md); cfg_count = 8'(n); cfg_half = 8'(hv);
      @(negedge clk); cfg_we = 0;
   endtask
   task automatic push(input logic [7:0] b);
      @(negedge clk); tx_push = 1; tx_data = b;
      @(negedge clk); tx_push = 0;
   endtask
   task automatic go();
      @(negedge clk); enable = 1; start = 1; rises = 0;
      @(negedge clk); start = 0;
   endtask
   task automatic wait_done();
      repeat (3) @(negedge clk);
      while (!ss_n) @(negedge clk);
      enable = 0;
      @(negedge clk);
   endtask
   task automatic pop_expect(input logic [7:0] e, input string tag);
      @(negedge clk);
      while (rx_empty) @(negedge clk);
      chk(rx_data == e, tag, rx_data, e);
      rx_pop = 1;
      @(negedge clk); rx_pop = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R2: reset state
      chk(ss_n && !sclk && !mosi && !busy && tx_empty && rx_empty && !tx_full && !rx_full,
          "R2 reset outputs", {ss_n, sclk, mosi, busy, tx_empty, rx_empty}, 6'b100011);

      // R1/R4/R5: mode 3, opcode + two address bytes, three reply frames
      cfg(3, 2, 2);
      push(8'h03); push(8'h12); push(8'h34);
      go();
      wait_done();
      chk(rises == 48, "R5 six frames on the wire", rises, 48);
      pop_expect(8'hA3, "R4 R5 first reply");
      pop_expect(8'hA4, "R5 second reply");
      pop_expect(8'hA5, "R5 third reply");
      chk(rx_empty, "R4 command frames not captured", rx_empty, 1);

      // R6: four queued frames, two replies; the fourth slot's data is lost
      cfg(3, 1, 1);
      push(8'h0B); push(8'h00); push(8'h10); push(8'hFF);
      go();
      wait_done();
      pop_expect(8'hA4, "R6 reply after extra frame");
      pop_expect(8'hA5, "R6 second reply");
      chk(rx_empty, "R6 no extra capture", rx_empty, 1);

      // R7: write while enabled ignored; mode stays 3 so start with empty tx does nothing
      @(negedge clk); enable = 1;
      cfg(2, 0, 1);
      @(negedge clk); start = 1;
      @(negedge clk); start = 0;
      repeat (8) @(negedge clk);
      chk(ss_n, "R7 locked mode kept, R1 start needs tx data", ss_n, 1);
      enable = 0;
      // R11: start while disabled ignored
      cfg(2, 0, 1);
      @(negedge clk); start = 1;
      @(negedge clk); start = 0;
      repeat (4) @(negedge clk);
      chk(ss_n && !busy, "R11 start ignored when disabled", ss_n, 1);

      // R8: fetch-only, two frames, half period 1
      cfg(2, 1, 1);
      go();
      wait_done();
      chk(rises == 16, "R8 two frames", rises, 16);
      pop_expect(8'hA0, "R8 frame 0");
      pop_expect(8'hA1, "R8 frame 1");

      // R9: full duplex, half period 3
      cfg(0, 0, 3);
      push(8'h5A); push(8'hC3);
      go();
      wait_done();
      pop_expect(8'hA0, "R9 duplex reply 0");
      pop_expect(8'hA1, "R9 duplex reply 1");
      // R9: send only, nothing captured
      cfg(1, 0, 2);
      push(8'h81); push(8'h7E);
      go();
      wait_done();
      chk(rx_empty && rises == 16, "R9 send only no capture", {rx_empty, 8'(rises)}, 16);

      // R10: ten-frame fetch with the receive queue left full
      cfg(2, 9, 1);
      go();
      while (!rx_full) @(negedge clk);
      repeat (20) @(negedge clk);
      chk(sclk && !ss_n, "R10 clock held high while full", {sclk, ss_n}, 2'b10);
      for (int i = 0; i < 10; i++) pop_expect(8'(8'hA0 + i), "R10 frame order kept");
      wait_done();

      // R12: nine pushes, eighth fills, ninth ignored; send all
      for (int i = 0; i < 9; i++) push(8'(8'h10 + i));
      chk(tx_full, "R12 tx full at 8", tx_full, 1);
      cfg(1, 0, 1);
      go();
      wait_done();
      chk(rises == 64, "R12 ninth push ignored", rises, 64);
      @(negedge clk); rx_pop = 1;
      @(negedge clk); rx_pop = 0;
      chk(rx_empty && !rx_full, "R12 pop on empty ignored", rx_empty, 1);

      // R11: abort by dropping enable
      cfg(2, 5, 2);
      go();
      repeat (20) @(negedge clk);
      enable = 0;
      @(negedge clk);
      chk(ss_n && !busy, "R11 abort releases select", ss_n, 1);
      repeat (4) @(negedge clk);
      chk(rx_empty, "R11 partial frame dropped", rx_empty, 1);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule